// File: doc/BRIEF.md
# Victim and Next-Victim Replacement Tracker

This block holds the replacement state for every set of a 4-way set-associative cache. Each set records two encoded way indices: the way to be evicted next (the victim) and the way that takes over that role once the victim is used (the next victim). Each index is two bits wide, so a set costs four bits of state. A design with one pair of flag bits per way would cost eight.

A cache controller presents the set it is updating together with a strobe. The strobe is either a hit, which carries a way index, or a fill, which always targets the set's current victim. The tracker moves the two indices on the following clock edge. Separately, the controller can query any set and read its current victim at once, with no added cycles.

Top module: `victim_tracker`

## Requirements
- R1: After a synchronous reset, every set holds victim way 0 and next-victim way 1.
- R2: Within a set, the victim index and the next-victim index never name the same way.
- R3: `victim_way` follows the victim field of set `qry_set` combinationally, and an update becomes visible there only after the next rising clock edge.
- R4: An access to the current victim makes the next victim the new victim. The new next victim is then the lowest-numbered way that is neither the new victim nor the accessed way.
- R5: An access to the current next victim keeps the victim unchanged. The new next victim is the lowest-numbered way that is neither the victim nor the accessed way.
- R6: An access to a way that is neither the victim nor the next victim leaves the set unchanged.
- R7: When `fill_valid` is high, the set is updated as an access to its own current victim, and this always changes its victim. If a hit is strobed in the same cycle, the fill takes precedence and the hit is ignored.
- R8: An update changes only set `upd_set`, and all other sets keep their state.
- R9: While `hit_valid` and `fill_valid` are both low, no set changes, whatever value `hit_way` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| upd_set | input | SET_W | Set being updated by a hit or fill |
| hit_valid | input | 1 | Strobe: `hit_way` of `upd_set` was accessed |
| hit_way | input | 2 | Accessed way index (binary) |
| fill_valid | input | 1 | Strobe: the victim way of `upd_set` was filled |
| qry_set | input | SET_W | Set whose victim is reported |
| victim_way | output | 2 | Current victim way of `qry_set` (binary) |

## Verification
The bench builds the tracker with four sets. This keeps the lowest and highest set indices, and a set beside the one being exercised, within a few cycles of stimulus. A single set is driven through every transition: a hit on the victim, a hit on the next victim, a hit on an unrelated way, a fill, and a fill colliding with a hit. Each step brings the next-victim choice round to a different way. The other sets are then read back to confirm they were not disturbed, and a reset in the middle of a run is shown to restore them all.

// File: rtl/repl_pkg.sv
package repl_pkg;

    localparam int WAYS  = 4;
    localparam int WAY_W = $clog2(WAYS);

    typedef logic [WAY_W-1:0] way_t;

    typedef struct packed {
        way_t v;
        way_t nv;
    } repl_entry_t;

    localparam repl_entry_t ENTRY_RESET = '{v: way_t'(0), nv: way_t'(1)};

    // Lowest-numbered way excluding both arguments.
    function automatic way_t lowest_free(way_t ex_a, way_t ex_b);
        way_t pick;
        pick = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_t'(w) != ex_a && way_t'(w) != ex_b)
                pick = way_t'(w);
        end
        return pick;
    endfunction

endpackage

// File: rtl/repl_state_mem.sv
module repl_state_mem
    import repl_pkg::*;
#(
    parameter int NUM_SETS = 16,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SET_W-1:0]  wset,
    input  repl_entry_t       wdata,
    input  logic [SET_W-1:0]  rset_a,
    output repl_entry_t       rdata_a,
    input  logic [SET_W-1:0]  rset_b,
    output repl_entry_t       rdata_b
);

    repl_entry_t entries [NUM_SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++)
                entries[s] <= ENTRY_RESET;
        end else if (we) begin
            entries[wset] <= wdata;
        end
    end

    assign rdata_a = entries[rset_a];
    assign rdata_b = entries[rset_b];

    // R2: every value written keeps the two indices apart
    a_r2_distinct_write: assert property (@(posedge clk) disable iff (rst)
        we |-> (wdata.v != wdata.nv));

    // R2: the read entry never holds equal indices
    a_r2_distinct_read: assert property (@(posedge clk) disable iff (rst)
        rdata_b.v != rdata_b.nv);

endmodule

// File: rtl/repl_update.sv
module repl_update
    import repl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  repl_entry_t cur,
    input  logic        acc_valid,
    input  way_t        acc_way,
    output repl_entry_t nxt,
    output logic        changed
);

    logic hit_v;
    logic hit_nv;

    assign hit_v  = acc_valid && (acc_way == cur.v);
    assign hit_nv = acc_valid && (acc_way == cur.nv);

    always_comb begin
        nxt     = cur;
        changed = 1'b0;
        if (hit_v) begin
            nxt.v   = cur.nv;
            nxt.nv  = lowest_free(cur.nv, acc_way);
            changed = 1'b1;
        end else if (hit_nv) begin
            nxt.v   = cur.v;
            nxt.nv  = lowest_free(cur.v, acc_way);
            changed = 1'b1;
        end
    end

    // R4: the victim always moves off the way just used
    a_r4_victim_leaves: assert property (@(posedge clk) disable iff (rst)
        hit_v |-> (nxt.v != acc_way && nxt.nv != acc_way));

    // R5: a next-victim access never disturbs the victim
    a_r5_victim_kept: assert property (@(posedge clk) disable iff (rst)
        hit_nv |-> (nxt.v == cur.v && nxt.nv != acc_way));

endmodule

// File: rtl/victim_tracker.sv
module victim_tracker
    import repl_pkg::*;
#(
    parameter int NUM_SETS = 16,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] upd_set,
    input  logic             hit_valid,
    input  logic [1:0]       hit_way,
    input  logic             fill_valid,
    input  logic [SET_W-1:0] qry_set,
    output logic [1:0]       victim_way
);

    repl_entry_t q_entry;
    repl_entry_t u_entry;
    repl_entry_t u_next;
    logic        u_changed;
    logic        acc_valid;
    way_t        acc_way;

    // A fill always lands in the victim and overrides any hit.
    assign acc_valid = fill_valid | hit_valid;
    assign acc_way   = fill_valid ? u_entry.v : way_t'(hit_way);

    repl_state_mem #(.NUM_SETS(NUM_SETS)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .we      (u_changed),
        .wset    (upd_set),
        .wdata   (u_next),
        .rset_a  (qry_set),
        .rdata_a (q_entry),
        .rset_b  (upd_set),
        .rdata_b (u_entry)
    );

    repl_update u_upd (
        .clk       (clk),
        .rst       (rst),
        .cur       (u_entry),
        .acc_valid (acc_valid),
        .acc_way   (acc_way),
        .nxt       (u_next),
        .changed   (u_changed)
    );

    assign victim_way = q_entry.v;

    // R7: a fill on the queried set always moves its victim
    a_r7_fill_moves: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && upd_set == qry_set) ##1 $stable(qry_set)
            |-> victim_way != $past(victim_way));

    // R9: without a strobe the reported victim holds
    a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!hit_valid && !fill_valid) ##1 $stable(qry_set) |-> $stable(victim_way));

    // R6: a hit on an unrelated way writes nothing
    a_r6_stray_hit: assert property (@(posedge clk) disable iff (rst)
        (hit_valid && !fill_valid && way_t'(hit_way) != u_entry.v
         && way_t'(hit_way) != u_entry.nv) |-> !u_changed);

endmodule

// File: tb/sim_victim_tracker.sv
module sim_victim_tracker;

    localparam int CLK_PERIOD = 10;
    localparam int NSETS      = 4;
    localparam int SW         = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [SW-1:0] upd_set = '0;
    logic          hit_valid = 1'b0;
    logic [1:0]    hit_way = '0;
    logic          fill_valid = 1'b0;
    logic [SW-1:0] qry_set = '0;
    logic [1:0]    victim_way;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    victim_tracker #(.NUM_SETS(NSETS)) u0 (
        .clk(clk), .rst(rst), .upd_set(upd_set), .hit_valid(hit_valid),
        .hit_way(hit_way), .fill_valid(fill_valid), .qry_set(qry_set),
        .victim_way(victim_way)
    );

    // {hit_valid, hit_way[1:0], fill_valid, expected victim[1:0]} on set 1
    localparam int NVEC = 9;
    localparam logic [5:0] VEC [NVEC] = '{
        {1'b1, 2'd2, 1'b0, 2'd0},  // R6 unrelated way
        {1'b1, 2'd1, 1'b0, 2'd0},  // R5 hit NV, NV->2
        {1'b1, 2'd0, 1'b0, 2'd2},  // R4 hit V, V=2 NV=1
        {1'b0, 2'd0, 1'b1, 2'd1},  // R7 fill, V=1 NV=0
        {1'b1, 2'd3, 1'b0, 2'd1},  // R6 unrelated way
        {1'b1, 2'd0, 1'b0, 2'd1},  // R5 hit NV, NV->2
        {1'b1, 2'd1, 1'b0, 2'd2},  // R4 hit V, V=2 NV=0
        {1'b0, 2'd0, 1'b1, 2'd0},  // R7 fill, V=0 NV=1
        {1'b1, 2'd2, 1'b1, 2'd1}   // R7 fill beats stray hit
    };

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: victim actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycle(input logic [SW-1:0] s, input logic hv, input logic [1:0] w,
                         input logic fv);
        @(negedge clk);
        upd_set = s; hit_valid = hv; hit_way = w; fill_valid = fv;
        @(posedge clk);
        #1;
        hit_valid = 1'b0; fill_valid = 1'b0;
    endtask

    task automatic peek(input logic [SW-1:0] s, input string req, input logic [1:0] exp);
        qry_set = s;
        #1;
        check(req, victim_way, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state on every set
        for (int s = 0; s < NSETS; s++) peek(SW'(s), "R1", 2'd0);

        // R3 query is combinational before any edge
        qry_set = 2'd1;
        @(negedge clk);
        upd_set = 2'd1; hit_valid = 1'b1; hit_way = 2'd0;
        #1 check("R3", victim_way, 2'd0);
        @(posedge clk); #1;
        hit_valid = 1'b0;
        check("R3", victim_way, 2'd1);    // R1 NV was 1
        cycle(2'd1, 1'b1, 2'd1, 1'b0);    // V=2 NV=0
        cycle(2'd1, 1'b1, 2'd2, 1'b0);    // V=0 NV=1, back to reset pattern
        peek(2'd1, "R4", 2'd0);

        for (int i = 0; i < NVEC; i++) begin
            qry_set = 2'd1;
            cycle(2'd1, VEC[i][5], VEC[i][4:3], VEC[i][2]);
            check($sformatf("vec%0d", i), victim_way, VEC[i][1:0]);
        end
        // set 1 now V=1 NV=2

        // R8 untouched neighbours
        peek(2'd0, "R8", 2'd0);
        peek(2'd2, "R8", 2'd0);

        // R9 hit_way moves with no strobe
        for (int w = 0; w < 4; w++) cycle(2'd1, 1'b0, 2'(w), 1'b0);
        peek(2'd1, "R9", 2'd1);

        // R8 highest set index, query elsewhere during update
        qry_set = 2'd1;
        cycle(2'd3, 1'b0, 2'd0, 1'b1);
        check("R8", victim_way, 2'd1);
        peek(2'd3, "R7", 2'd1);
        cycle(2'd3, 1'b1, 2'd1, 1'b0);    // V=1 -> V=2 NV=0
        peek(2'd3, "R4", 2'd2);
        cycle(2'd3, 1'b1, 2'd0, 1'b0);    // NV hit -> NV=1
        cycle(2'd3, 1'b1, 2'd2, 1'b0);    // V -> V=1 (R5 result)
        peek(2'd3, "R5", 2'd1);
        cycle(2'd3, 1'b1, 2'd1, 1'b0);    // V=1 NV=0 -> V=0
        peek(2'd3, "R2", 2'd0);

        // R1 mid-run reset
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        peek(2'd1, "R1", 2'd0);
        peek(2'd3, "R1", 2'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule